// File: doc/BRIEF.md
# Floating-Point Exception Status Register

This block holds the mode and status word of a floating-point coprocessor. The word carries a three-bit trap-type code, two sticky flags (underflow and inexact), a trap enable for each of those two conditions, a two-bit rounding-mode selector and a seven-bit scratch field for software. Bits 31 to 16 are reserved and read as zero.

The arithmetic datapath reports each completed instruction with a valid strobe and a vector of raised conditions. The block picks one code by a fixed priority and records it. It updates the sticky flags. In the same cycle it tells the datapath whether to trap, whether to withhold the result, and whether to force a positive zero. Software loads the word through a write strobe. It stores the word by reading `stat_o`, which has no side effect.

Top module: `fpx_status_reg`

## Requirements
- R1: While reset is asserted, and after it, `stat_o` is all zero and `rnd_mode_o` is 00.
- R2: A load (`ld_en`=1) writes `ld_data[15:0]` into the word. The result is visible on `stat_o` one clock later. Bits 31:16 of `stat_o` always read zero.
- R3: A report (`rpt_valid`=1, no load) sets the trap-type field in bits 2:0 to one code. The `rpt_exc` bits are: 0 underflow, 1 overflow, 2 divide-by-zero, 3 illegal, 4 invalid, 5 inexact. The codes are: illegal 100, invalid 101, divide-by-zero 011, overflow 010, underflow 001, inexact 110. When several bits are set, the code follows that priority order, with illegal highest and inexact lowest.
- R4: A report with no bits set loads 000 into the trap-type field. Cycles without a report or a load leave the whole word unchanged, so reading the word never alters it.
- R5: The underflow flag (bit 4) is set by every report that has an underflow bit. This holds whether or not the underflow enable (bit 3) is set and whatever code is recorded. Only a load can clear the flag.
- R6: The inexact flag (bit 6) is set only when inexact is the recorded code. When inexact is reported together with another condition, the flag keeps its old value. Only a load can clear the flag.
- R7: In the report cycle, `quit_o` is high when the recorded code is overflow, divide-by-zero, illegal or invalid. It is also high for underflow when bit 3 is set, and for inexact when bit 5 is set. Otherwise it is low.
- R8: `commit_inhibit_o` follows `quit_o`. `force_zero_o` is high in the report cycle only when underflow is recorded and bit 3 is clear.
- R9: `rnd_mode_o` shows bits 8:7 of the word. The codes are 00 nearest-even, 01 toward zero, 10 toward plus infinity and 11 toward minus infinity.
- R10: When a load and a report happen in the same cycle, the load wins. The report is ignored: the word takes the loaded value, and `quit_o` and `force_zero_o` stay low.
- R11: The software field (bits 15:9) changes only through a load. Reports never alter it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| ld_en | input | 1 | Software load strobe |
| ld_data | input | 32 | Load value. Bits 15:0 are used. |
| rpt_valid | input | 1 | Datapath report strobe, one per completed instruction |
| rpt_exc | input | 6 | Raised conditions: 0 underflow, 1 overflow, 2 divide-by-zero, 3 illegal, 4 invalid, 5 inexact |
| stat_o | output | 32 | Current status word |
| rnd_mode_o | output | 2 | Current rounding mode |
| quit_o | output | 1 | Trap request for the reporting instruction |
| commit_inhibit_o | output | 1 | Do not write the result of the reporting instruction |
| force_zero_o | output | 1 | Replace the result with positive zero (underflow, trap disabled) |

## Verification
`quit_o`, `commit_inhibit_o` and `force_zero_o` are combinational on the report. They are due in the same cycle as the report. The bench checks them one nanosecond after it drives the inputs at the falling edge. The word and the rounding mode pass through one register, so they are due at the next rising edge. The driver queues one expected item per driven cycle, and a monitor compares it one nanosecond after that edge. Because the queue is filled every cycle, idle cycles are checked as well, so changes that were not asked for also show up.

// File: rtl/fsr_pkg.sv
package fsr_pkg;
  localparam int EXC_W = 6;
  localparam int EXC_UNF = 0;
  localparam int EXC_OVF = 1;
  localparam int EXC_DVZ = 2;
  localparam int EXC_ILL = 3;
  localparam int EXC_INV = 4;
  localparam int EXC_INX = 5;

  typedef enum logic [2:0] {
    TT_NONE  = 3'b000,
    TT_UNF   = 3'b001,
    TT_OVF   = 3'b010,
    TT_DVZ   = 3'b011,
    TT_ILL   = 3'b100,
    TT_INV   = 3'b101,
    TT_INX   = 3'b110
  } tt_e;

  // Packed word: first field is the most significant.
  typedef struct packed {
    logic [6:0] swf;      // 15:9 software scratch
    logic [1:0] rnd;      // 8:7 rounding mode
    logic       inx_flag; // 6
    logic       inx_en;   // 5
    logic       unf_flag; // 4
    logic       unf_en;   // 3
    logic [2:0] tt;       // 2:0 trap type
  } fsr_t;

  localparam int FSR_W = $bits(fsr_t);
endpackage

// File: rtl/fsr_rst_sync.sv
module fsr_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] sh_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= {sh_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_sync = sh_q[STAGES-1];
endmodule

// File: rtl/fsr_classify.sv
module fsr_classify
  import fsr_pkg::*;
(
  input  logic             valid,
  input  logic [EXC_W-1:0] exc,
  input  logic             unf_en,
  input  logic             inx_en,
  output logic             rec,
  output tt_e              code,
  output logic             trap,
  output logic             force_zero,
  output logic             set_unf,
  output logic             set_inx
);
  always_comb begin
    // Priority: illegal, invalid, divide-by-zero, overflow, underflow, inexact.
    if      (exc[EXC_ILL]) code = TT_ILL;
    else if (exc[EXC_INV]) code = TT_INV;
    else if (exc[EXC_DVZ]) code = TT_DVZ;
    else if (exc[EXC_OVF]) code = TT_OVF;
    else if (exc[EXC_UNF]) code = TT_UNF;
    else if (exc[EXC_INX]) code = TT_INX;
    else                   code = TT_NONE;
  end

  always_comb begin
    rec        = valid;
    set_unf    = valid & exc[EXC_UNF];
    set_inx    = valid & (code == TT_INX);
    force_zero = valid & (code == TT_UNF) & ~unf_en;
    unique case (code)
      TT_OVF, TT_DVZ, TT_ILL, TT_INV: trap = valid;
      TT_UNF:                         trap = valid & unf_en;
      TT_INX:                         trap = valid & inx_en;
      default:                        trap = 1'b0;
    endcase
  end
endmodule

// File: rtl/fsr_regs.sv
module fsr_regs
  import fsr_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  input  fsr_t wdata,
  input  logic rec,
  input  tt_e  code,
  input  logic set_unf,
  input  logic set_inx,
  output fsr_t q
);
  fsr_t d;
  logic upd_en;

  assign upd_en = load | rec;

  always_comb begin
    d = q;
    if (load) begin
      d = wdata;
    end else begin
      if (rec)     d.tt       = code;
      if (set_unf) d.unf_flag = 1'b1;
      if (set_inx) d.inx_flag = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      q <= '0;
    else if (upd_en) q <= d;
  end

  assert_unf_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (q.unf_flag && !load) |=> q.unf_flag);
  assert_inx_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (q.inx_flag && !load) |=> q.inx_flag);
  assert_tt_cleared_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (rec && !load && code == TT_NONE) |=> q.tt == 3'b000);
  assert_idle_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!rec && !load) |=> $stable(q));
  assert_swf_only_load_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> $stable(q.swf));
  assert_tt_legal_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (rec && !load) |=> q.tt != 3'b111);
endmodule

// File: rtl/fpx_status_reg.sv
module fpx_status_reg
  import fsr_pkg::*;
#(
  parameter int REG_W       = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ld_en,
  input  logic [REG_W-1:0] ld_data,
  input  logic             rpt_valid,
  input  logic [EXC_W-1:0] rpt_exc,
  output logic [REG_W-1:0] stat_o,
  output logic [1:0]       rnd_mode_o,
  output logic             quit_o,
  output logic             commit_inhibit_o,
  output logic             force_zero_o
);
  localparam int PAD_W = REG_W - FSR_W;

  logic rst_n_int;
  logic rpt_live;
  logic rec, trap, fz, set_unf, set_inx;
  tt_e  code;
  fsr_t fsr_q;
  fsr_t ld_word;

  fsr_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_int)
  );

  // A load in the same cycle takes precedence over a report.
  assign rpt_live = rpt_valid & ~ld_en;
  assign ld_word  = fsr_t'(ld_data[FSR_W-1:0]);

  fsr_classify u_cls (
    .valid      (rpt_live),
    .exc        (rpt_exc),
    .unf_en     (fsr_q.unf_en),
    .inx_en     (fsr_q.inx_en),
    .rec        (rec),
    .code       (code),
    .trap       (trap),
    .force_zero (fz),
    .set_unf    (set_unf),
    .set_inx    (set_inx)
  );

  fsr_regs u_regs (
    .clk     (clk),
    .rst_n   (rst_n_int),
    .load    (ld_en),
    .wdata   (ld_word),
    .rec     (rec),
    .code    (code),
    .set_unf (set_unf),
    .set_inx (set_inx),
    .q       (fsr_q)
  );

  assign stat_o           = {{PAD_W{1'b0}}, fsr_q};
  assign rnd_mode_o       = fsr_q.rnd;
  assign quit_o           = trap;
  assign commit_inhibit_o = trap;
  assign force_zero_o     = fz;

  assert_quit_hard_R7: assert property (@(posedge clk) disable iff (!rst_n_int)
    (rpt_valid && !ld_en && (rpt_exc[EXC_OVF] || rpt_exc[EXC_DVZ] ||
     rpt_exc[EXC_ILL] || rpt_exc[EXC_INV])) |-> quit_o);
  assert_load_wins_R10: assert property (@(posedge clk) disable iff (!rst_n_int)
    ld_en |-> (!quit_o && !force_zero_o));
  assert_zero_no_trap_R8: assert property (@(posedge clk) disable iff (!rst_n_int)
    force_zero_o |-> (!commit_inhibit_o && rpt_exc[EXC_UNF]));
  assert_load_lands_R2: assert property (@(posedge clk) disable iff (!rst_n_int)
    ld_en |=> stat_o[FSR_W-1:0] == $past(ld_data[FSR_W-1:0]));
endmodule

// File: tb/fpx_status_reg_bench.sv
module fpx_status_reg_bench;
  localparam time TCK = 8ns;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ld_en = 1'b0;
  logic [31:0] ld_data = '0;
  logic        rpt_valid = 1'b0;
  logic [5:0]  rpt_exc = '0;
  logic [31:0] stat_o;
  logic [1:0]  rnd_mode_o;
  logic        quit_o, commit_inhibit_o, force_zero_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  typedef struct {
    logic [31:0] stat;
    logic [1:0]  rnd;
    string       tag;
  } exp_t;
  exp_t sb[$];
  logic [31:0] model = '0;

  always #(TCK/2) clk = ~clk;

  fpx_status_reg u_fpx_status_reg (
    .clk(clk), .rst_n(rst_n), .ld_en(ld_en), .ld_data(ld_data),
    .rpt_valid(rpt_valid), .rpt_exc(rpt_exc), .stat_o(stat_o),
    .rnd_mode_o(rnd_mode_o), .quit_o(quit_o),
    .commit_inhibit_o(commit_inhibit_o), .force_zero_o(force_zero_o)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // Driver: apply one cycle, check same-cycle outputs, queue the next word.
  task automatic step(input logic ld, input logic [31:0] d, input logic v,
                      input logic [5:0] e, input string tag);
    logic [31:0] nxt;
    logic [2:0]  c;
    logic        q, fz;
    @(negedge clk);
    ld_en = ld; ld_data = d; rpt_valid = v; rpt_exc = e;
    nxt = model; q = 0; fz = 0;
    if (ld) begin
      nxt = {16'h0, d[15:0]};
    end else if (v) begin
      if      (e[3]) c = 3'b100;
      else if (e[4]) c = 3'b101;
      else if (e[2]) c = 3'b011;
      else if (e[1]) c = 3'b010;
      else if (e[0]) c = 3'b001;
      else if (e[5]) c = 3'b110;
      else           c = 3'b000;
      nxt[2:0] = c;
      if (e[0]) nxt[4] = 1'b1;
      if (c == 3'b110) nxt[6] = 1'b1;
      q  = (c inside {3'b010, 3'b011, 3'b100, 3'b101}) ||
           (c == 3'b001 && model[3]) || (c == 3'b110 && model[5]);
      fz = (c == 3'b001) && !model[3];
    end
    #1;
    check({tag, " quit"}, {31'b0, quit_o}, {31'b0, q});
    check({tag, " inhibit"}, {31'b0, commit_inhibit_o}, {31'b0, q});
    check({tag, " zero"}, {31'b0, force_zero_o}, {31'b0, fz});
    sb.push_back('{stat: nxt, rnd: nxt[8:7], tag: tag});
    model = nxt;
  endtask

  // Monitor: compare registered results one edge after each driven cycle.
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (sb.size() > 0) begin
        exp_t x;
        x = sb.pop_front();
        check({x.tag, " word"}, stat_o, x.stat);
        check({x.tag, " rnd R9"}, {30'b0, rnd_mode_o}, {30'b0, x.rnd});
      end
    end
  end

  initial begin
    #(TCK * 200000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 check("R1 reset word", stat_o, 32'h0);
    check("R1 reset rnd", {30'b0, rnd_mode_o}, 32'h0);
    @(negedge clk) rst_n = 1'b1;
    repeat (3) @(posedge clk);
    step(0, 0, 0, 6'h00, "R1 idle after reset");
    step(1, 32'hDEAD_3E18, 0, 6'h00, "R2 load upper dropped");
    step(0, 0, 0, 6'h00, "R4 idle hold");
    step(1, 32'h0000_0000, 0, 6'h00, "R2 load zero");
    step(0, 0, 1, 6'h01, "R3 underflow alone");
    step(0, 0, 1, 6'h02, "R3 overflow alone");
    step(0, 0, 1, 6'h04, "R3 divzero alone");
    step(0, 0, 1, 6'h08, "R3 illegal alone");
    step(0, 0, 1, 6'h10, "R3 invalid alone");
    step(0, 0, 1, 6'h00, "R4 clean clears code");
    step(0, 0, 1, 6'h3F, "R3 all bits illegal wins");
    step(0, 0, 1, 6'h14, "R3 invalid over divzero");
    step(0, 0, 1, 6'h06, "R3 divzero over overflow");
    step(0, 0, 1, 6'h03, "R5 overflow with underflow flag");
    step(1, 32'h0000_0000, 0, 6'h00, "R5 load clears flags");
    step(0, 0, 1, 6'h21, "R6 inexact with underflow keeps IF");
    step(0, 0, 1, 6'h20, "R6 inexact alone sets IF");
    step(0, 0, 1, 6'h22, "R6 inexact with overflow");
    step(0, 0, 0, 6'h3F, "R4 no strobe ignored");
    step(1, 32'h0000_0028, 0, 6'h00, "R7 enable both traps");
    step(0, 0, 1, 6'h01, "R7 underflow trapped");
    step(0, 0, 1, 6'h20, "R7 inexact trapped");
    step(0, 0, 1, 6'h21, "R8 underflow trapped no zero");
    step(1, 32'h0000_0100, 1, 6'h02, "R10 load beats report");
    step(1, 32'h0000_0080, 0, 6'h00, "R9 toward zero");
    step(1, 32'h0000_0180, 0, 6'h00, "R9 toward minus inf");
    step(1, 32'h0000_FE00, 0, 6'h00, "R11 set software field");
    step(0, 0, 1, 6'h25, "R11 report keeps software field");
    step(0, 0, 1, 6'h00, "R11 clean keeps software field");
    step(0, 0, 0, 6'h00, "drain");
    repeat (2) @(posedge clk);
    #2;
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule